// File: doc/BRIEF.md
# Mode-Aware Interrupt Priority Selector

This block keeps one pending flag for each of seven interrupt sources and decides, every cycle, whether the processor should take an interrupt now. When it should, the block also names the winning source. Each flag is raised by a one-cycle set pulse and dropped by a one-cycle clear pulse. A clear pulse may stand for a register write, a register read, or a mode bit falling; the block does not care which.

Which sources may win depends on two live inputs: the hypervisor-privilege flag and the global interrupt-enable flag. In hypervisor mode, only the hypervisor-interrupt and interrupt-vector sources can win, and only while interrupts are enabled. Outside hypervisor mode, the three most urgent sources win regardless of the enable flag. The other four win only while it is set. The decision is combinational from the registered flags and the current mode inputs, so a mode change shows up in the same cycle.

Source indices, from highest to lowest priority:
- 0: trap-level-zero
- 1: hypervisor interrupt
- 2: interrupt vector
- 3: processor mondo
- 4: device mondo
- 5: soft interrupt
- 6: resumable error

Top module: `irq_prio_sel`

## Requirements
- R1: An active-low reset clears every pending flag, so `any_pend_o` and `take_o` read 0 after reset.
- R2: A set pulse on bit k makes source k pending from the next clock edge, and `any_pend_o` then reads 1.
- R3: A clear pulse on bit k, with no set pulse on bit k, drops source k at the next edge. If set and clear arrive in the same cycle, the source stays or becomes pending.
- R4: With no source pending, `take_o` is 0 in every mode.
- R5: With `hyp_i`=1, only source 1 and source 2 can win (in that order), and only while `ie_i`=1.
- R6: With `hyp_i`=1, sources 0, 3, 4, 5 and 6 never make `take_o` high, even when pending.
- R7: With `hyp_i`=0, sources 0, 1 and 2 are taken whatever the value of `ie_i`.
- R8: With `hyp_i`=0, sources 3, 4, 5 and 6 are taken only while `ie_i`=1.
- R9: Among eligible pending sources, the lowest index wins. `win_o` carries that index as a 3-bit binary value and reads 0 whenever `take_o` is 0.
- R10: `take_o` and `win_o` follow changes of `hyp_i` and `ie_i` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 7 | Per-source set pulses, bit = source index |
| clr_i | input | 7 | Per-source clear pulses, bit = source index |
| hyp_i | input | 1 | Hypervisor-privilege mode flag |
| ie_i | input | 1 | Global interrupt-enable flag |
| take_o | output | 1 | An interrupt should be taken now |
| win_o | output | 3 | Index of the winning source |
| any_pend_o | output | 1 | At least one source is pending |

## Verification
Two functions can fall in the same cycle: the set path and the clear path of a single source. The bench provokes this by pulsing both bits of one source together, once while that source is already pending and once while it is idle. The case is judged by whether that source is still the winner after the edge. The bench also lands a clear of the current winner in the same cycle as a set of a lower source, and expects the winner to move to the new source at once.

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int              NSRC     = 7,
  parameter int              IDXW     = $clog2(NSRC),
  parameter logic [NSRC-1:0] HYP_OK   = 7'b0000110,
  parameter logic [NSRC-1:0] NOGATE   = 7'b0000111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            hyp_i,
  input  logic            ie_i,
  output logic            take_o,
  output logic [IDXW-1:0] win_o,
  output logic            any_pend_o
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] pick;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_i) | set_i;
  end

  assign elig = hyp_i ? (ie_i ? HYP_OK : '0)
                      : (ie_i ? '1 : NOGATE);
  assign pick = pend & elig;

  always_comb begin
    win_o = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pick[i]) win_o = IDXW'(i);
  end

  assign take_o     = |pick;
  assign any_pend_o = |pend;

  p_idle_no_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend_o |-> !take_o) else $error("R4 take without pending");

  p_hyp_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && hyp_i) |-> (ie_i && (win_o == IDXW'(1) || win_o == IDXW'(2))))
    else $error("R5/R6 hyp winner out of set");

  p_gated_need_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !hyp_i && win_o >= IDXW'(3)) |-> ie_i)
    else $error("R8 gated source taken with ie low");

  p_win_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pend[win_o]) else $error("R9 winner not pending");

  p_win_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (win_o == '0)) else $error("R9 win not zero");

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> (pend[k] && any_pend_o)) else $error("R2/R3 set lost");
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !pend[k]) else $error("R3 clear ignored");
  end

endmodule

// File: tb/irq_prio_sel_tb.sv
module irq_prio_sel_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] set_i = '0, clr_i = '0;
  logic       hyp_i = 0, ie_i = 0;
  logic       take_o, any_pend_o;
  logic [2:0] win_o;

  always #2.5 clk = ~clk;

  irq_prio_sel u_dut (.clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
    .hyp_i(hyp_i), .ie_i(ie_i), .take_o(take_o), .win_o(win_o), .any_pend_o(any_pend_o));

  typedef struct { logic take; logic [2:0] win; logic any; string tag; } exp_t;
  exp_t q[$];
  event chk_ev;
  int   runs = 0, fails = 0;
  bit   done = 0;
  logic [6:0] model = '0;

  function automatic bit allowed(int s, logic h, logic e);
    if (h) return e && (s == 1 || s == 2);
    if (s <= 2) return 1'b1;
    return e;
  endfunction

  task automatic push_exp(string tag);
    exp_t x;
    x.take = 0; x.win = 0; x.any = |model; x.tag = tag;
    for (int s = 0; s < 7; s++)
      if (!x.take && model[s] && allowed(s, hyp_i, ie_i)) begin
        x.take = 1; x.win = 3'(s);
      end
    q.push_back(x);
    -> chk_ev;
  endtask

  task automatic step(logic [6:0] s, logic [6:0] c, logic h, logic e, string tag);
    @(negedge clk);
    set_i = s; clr_i = c; hyp_i = h; ie_i = e;
    @(posedge clk);
    model = (model & ~c) | s;
    #1; set_i = '0; clr_i = '0;
    push_exp(tag);
  endtask

  task automatic mode(logic h, logic e, string tag);
    @(negedge clk);
    hyp_i = h; ie_i = e;
    #1; push_exp(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    model = '0;
    @(negedge clk); rst_n = 1;
    #1; push_exp("R1");
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        runs++;
        if (take_o !== x.take || win_o !== x.win || any_pend_o !== x.any) begin
          fails++;
          $display("FAIL %s: actual take=%b win=%0d any=%b expected take=%b win=%0d any=%b",
                   x.tag, take_o, win_o, any_pend_o, x.take, x.win, x.any);
        end
      end
    end
  end

  initial begin
    do_reset();
    step('0, '0, 0, 1, "R4");
    mode(1, 1, "R4");
    step(7'b0100000, '0, 0, 0, "R8 R2");
    mode(0, 1, "R8 R10");
    step(7'b1000000, '0, 0, 1, "R9");
    step('0, 7'b0100000, 0, 1, "R3");
    step(7'b0000001, '0, 0, 0, "R7");
    mode(1, 1, "R6");
    step(7'b0000010, '0, 1, 1, "R5");
    mode(1, 0, "R5");
    mode(0, 0, "R7 R9");
    step('0, 7'b0000001, 0, 0, "R7");
    step(7'b0000100, 7'b0000010, 0, 0, "R3 R7");
    step(7'b0000100, 7'b0000100, 0, 0, "R3");
    step('0, 7'b0000100, 0, 0, "R3");
    step(7'b0000100, 7'b0000100, 0, 0, "R3");
    step(7'b0011000, '0, 0, 1, "R9");
    step('0, 7'b0000100, 0, 1, "R9");
    step('0, 7'b0001000, 0, 1, "R9");
    mode(1, 1, "R6");
    mode(0, 0, "R8");
    step(7'b1111111, '0, 0, 1, "R9");
    do_reset();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule